// File: doc/BRIEF.md
# Multithreaded Pipeline Thread Selector

This block decides, every clock cycle, which hardware thread of a fine-grain multithreaded scalar core may fetch or issue next. It keeps a small amount of state per thread: whether the thread is held by an outstanding cache miss, whether it is held by a long-latency operation, and whether it has run ahead of a load that was assumed to hit. The pipeline, caches and functional units report events to it as one-cycle pulses, and it returns a one-hot grant with a valid flag.

A thread can be chosen only if it is ready and is not held by either kind of stall. Eligible threads fall into two tiers. A thread that is speculating on a load hit is in the lower tier, and every other eligible thread is in the upper tier. Within a tier the choice rotates round-robin from a shared pointer. After each grant the pointer moves to the thread that follows the one granted. The default configuration has four threads.

Top module: `thread_selector`

## Requirements
- R1: When grantValid is 1, grant has exactly one bit set. When grantValid is 0, grant is all zero. grantValid is 1 exactly when at least one thread is eligible. A thread is eligible when its threadReady bit is 1 and it has neither a miss stall nor a long-operation stall.
- R2: The grant goes to the first thread in the selected tier, searching upward from the round-robin pointer and wrapping from thread NUM_THREADS-1 to thread 0. After a grant of thread g, the pointer becomes (g+1) mod NUM_THREADS.
- R3: An eligible speculative thread is granted only in a cycle in which no eligible non-speculative thread exists.
- R4: A missSet pulse on a thread blocks that thread from the following cycle onward. A fillDone pulse clears the block, and the thread is eligible again in the next cycle.
- R5: A longOpSet pulse on a thread blocks that thread from the following cycle onward. A longOpDone pulse clears the block, and the thread is eligible again in the next cycle. This block is independent of the miss stall.
- R6: A specIssue pulse places the thread in the low-priority tier from the next cycle. A loadHit pulse returns the thread to the normal tier from the next cycle.
- R7: A loadMiss pulse clears the thread's speculative state and applies a miss stall from the next cycle. The stall is then cleared by fillDone.
- R8: In a cycle with no eligible thread, grantValid is 0 and the round-robin pointer keeps its value.
- R9: If a stall is set and cleared in the same cycle, the set wins. If specIssue arrives in the same cycle as loadHit or loadMiss, the thread stays speculative.
- R10: Reset clears all stall and speculative state and sets the pointer to thread 0. With every thread ready, the first grant after reset goes to thread 0.
- R11: A thread whose threadReady bit is 0 is never granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| threadReady | input | NUM_THREADS | Thread has work to fetch or issue |
| missSet | input | NUM_THREADS | Pulse: thread took a cache miss |
| fillDone | input | NUM_THREADS | Pulse: miss data returned, wakes the thread |
| longOpSet | input | NUM_THREADS | Pulse: thread started a long-latency operation |
| longOpDone | input | NUM_THREADS | Pulse: long-latency operation finished |
| specIssue | input | NUM_THREADS | Pulse: thread issued past a load assumed to hit |
| loadHit | input | NUM_THREADS | Pulse: speculated load confirmed as a hit |
| loadMiss | input | NUM_THREADS | Pulse: speculated load turned out to miss |
| grant | output | NUM_THREADS | One-hot selected thread |
| grantValid | output | 1 | A thread is selected this cycle |

## Verification
Two kinds of event can land on the same thread in the same cycle. A stall can be set while its wake-up pulse also arrives, and a new speculative load can issue while the previous one resolves as a hit or a miss. Directed cycles drive each of these pairs together, and a random phase makes them happen often by accident. The bench model applies each rule on its own, with set-before-clear ordering, and checks the grant and valid flag on every cycle. In later cycles it also checks which tier the thread landed in and whether the thread was blocked.

// File: rtl/thread_sel_pkg.sv
package thread_sel_pkg;
  // Per-thread strobes from control to the arbitration datapath
  typedef struct packed {
    logic eligible;
    logic speculative;
  } thr_strobe_t;
endpackage

// File: rtl/thread_sel_ctrl.sv
module thread_sel_ctrl #(
  parameter int NUM_THREADS = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic [NUM_THREADS-1:0] threadReady,
  input  logic [NUM_THREADS-1:0] missSet,
  input  logic [NUM_THREADS-1:0] fillDone,
  input  logic [NUM_THREADS-1:0] longOpSet,
  input  logic [NUM_THREADS-1:0] longOpDone,
  input  logic [NUM_THREADS-1:0] specIssue,
  input  logic [NUM_THREADS-1:0] loadHit,
  input  logic [NUM_THREADS-1:0] loadMiss,
  output thread_sel_pkg::thr_strobe_t [NUM_THREADS-1:0] thrStb
);
  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    logic missStall, longStall, specFlag;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        missStall <= 1'b0;
        longStall <= 1'b0;
        specFlag  <= 1'b0;
      end else begin
        // a new stall event outranks a wake-up in the same cycle
        missStall <= (missStall & ~fillDone[t]) | missSet[t] | loadMiss[t];
        longStall <= (longStall & ~longOpDone[t]) | longOpSet[t];
        // a fresh speculative load outranks resolution of the old one
        specFlag  <= (specFlag & ~(loadHit[t] | loadMiss[t])) | specIssue[t];
      end
    end

    assign thrStb[t].eligible    = threadReady[t] & ~missStall & ~longStall;
    assign thrStb[t].speculative = specFlag;
  end
endmodule

// File: rtl/thread_sel_dp.sv
module thread_sel_dp #(
  parameter int NUM_THREADS = 4
) (
  input  logic clk,
  input  logic rstN,
  input  thread_sel_pkg::thr_strobe_t [NUM_THREADS-1:0] thrStb,
  output logic [NUM_THREADS-1:0] grant,
  output logic grantValid,
  output logic [((NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1)-1:0] rrPtr
);
  localparam int IDX_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1;

  logic [NUM_THREADS-1:0] hiReq, loReq;
  logic [IDX_W-1:0] grantIdx;

  always_comb begin
    for (int t = 0; t < NUM_THREADS; t++) begin
      hiReq[t] = thrStb[t].eligible & ~thrStb[t].speculative;
      loReq[t] = thrStb[t].eligible &  thrStb[t].speculative;
    end
  end

  always_comb begin
    logic hiFound, loFound;
    int hiIdx, loIdx;
    hiFound = 1'b0;
    loFound = 1'b0;
    hiIdx   = 0;
    loIdx   = 0;
    for (int off = 0; off < NUM_THREADS; off++) begin
      int pos;
      pos = int'(rrPtr) + off;
      if (pos >= NUM_THREADS) pos = pos - NUM_THREADS;
      if (!hiFound && hiReq[pos]) begin
        hiFound = 1'b1;
        hiIdx   = pos;
      end
      if (!loFound && loReq[pos]) begin
        loFound = 1'b1;
        loIdx   = pos;
      end
    end
    grantValid = hiFound | loFound;
    grantIdx   = hiFound ? IDX_W'(hiIdx) : IDX_W'(loIdx);
    grant      = '0;
    if (grantValid) grant[grantIdx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rrPtr <= '0;
    end else if (grantValid) begin
      rrPtr <= (int'(grantIdx) == NUM_THREADS - 1) ? '0 : grantIdx + 1'b1;
    end
  end
endmodule

// File: rtl/thread_selector.sv
module thread_selector #(
  parameter int NUM_THREADS = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic [NUM_THREADS-1:0] threadReady,
  input  logic [NUM_THREADS-1:0] missSet,
  input  logic [NUM_THREADS-1:0] fillDone,
  input  logic [NUM_THREADS-1:0] longOpSet,
  input  logic [NUM_THREADS-1:0] longOpDone,
  input  logic [NUM_THREADS-1:0] specIssue,
  input  logic [NUM_THREADS-1:0] loadHit,
  input  logic [NUM_THREADS-1:0] loadMiss,
  output logic [NUM_THREADS-1:0] grant,
  output logic grantValid
);
  localparam int IDX_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1;

  thread_sel_pkg::thr_strobe_t [NUM_THREADS-1:0] thrStb;
  logic [IDX_W-1:0] rrPtr;

  thread_sel_ctrl #(.NUM_THREADS(NUM_THREADS)) ctrl_i (
    .clk(clk), .rstN(rstN), .threadReady(threadReady),
    .missSet(missSet), .fillDone(fillDone),
    .longOpSet(longOpSet), .longOpDone(longOpDone),
    .specIssue(specIssue), .loadHit(loadHit), .loadMiss(loadMiss),
    .thrStb(thrStb)
  );

  thread_sel_dp #(.NUM_THREADS(NUM_THREADS)) dp_i (
    .clk(clk), .rstN(rstN), .thrStb(thrStb),
    .grant(grant), .grantValid(grantValid), .rrPtr(rrPtr)
  );
endmodule

// File: rtl/thread_selector_chk.sv
module thread_selector_chk #(
  parameter int NUM_THREADS = 4,
  parameter int IDX_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input logic clk,
  input logic rstN,
  input logic [NUM_THREADS-1:0] threadReady,
  input logic [NUM_THREADS-1:0] missSet,
  input logic [NUM_THREADS-1:0] longOpSet,
  input logic [NUM_THREADS-1:0] loadMiss,
  input logic [NUM_THREADS-1:0] grant,
  input logic grantValid,
  input logic [2*NUM_THREADS-1:0] thrStbFlat,
  input logic [IDX_W-1:0] rrPtr
);
  logic [NUM_THREADS-1:0] eligV, specV;
  always_comb begin
    for (int t = 0; t < NUM_THREADS; t++) begin
      eligV[t] = thrStbFlat[2*t+1];
      specV[t] = thrStbFlat[2*t];
    end
  end

  a_r1_onehot: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |-> $countones(grant) == 1);

  a_r1_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    !grantValid |-> grant == '0);

  a_r11_ready_only: assert property (@(posedge clk) disable iff (!rstN)
    (grant & ~threadReady) == '0);

  // covers R4, R5 and R7: a stall event blocks the thread next cycle
  a_r4_stall_blocks: assert property (@(posedge clk) disable iff (!rstN)
    (|(missSet | longOpSet | loadMiss)) |=>
      (grant & $past(missSet | longOpSet | loadMiss)) == '0);

  a_r3_low_tier: assert property (@(posedge clk) disable iff (!rstN)
    (grantValid && |(eligV & ~specV)) |-> (grant & specV) == '0);

  a_r8_ptr_hold: assert property (@(posedge clk) disable iff (!rstN)
    !grantValid |=> rrPtr == $past(rrPtr));
endmodule

bind thread_selector thread_selector_chk #(.NUM_THREADS(NUM_THREADS)) chk_i (
  .clk(clk), .rstN(rstN), .threadReady(threadReady),
  .missSet(missSet), .longOpSet(longOpSet), .loadMiss(loadMiss),
  .grant(grant), .grantValid(grantValid),
  .thrStbFlat(thrStb), .rrPtr(rrPtr)
);

// File: tb/thread_selector_tb_top.sv
module thread_selector_tb_top;
  localparam int N = 4;
  localparam time CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [N-1:0] threadReady = '0, missSet = '0, fillDone = '0, longOpSet = '0;
  logic [N-1:0] longOpDone = '0, specIssue = '0, loadHit = '0, loadMiss = '0;
  logic [N-1:0] grant;
  logic grantValid;

  thread_selector #(.NUM_THREADS(N)) dut_i (
    .clk(clk), .rstN(rstN), .threadReady(threadReady),
    .missSet(missSet), .fillDone(fillDone),
    .longOpSet(longOpSet), .longOpDone(longOpDone),
    .specIssue(specIssue), .loadHit(loadHit), .loadMiss(loadMiss),
    .grant(grant), .grantValid(grantValid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference state
  bit mStall[N], lStall[N], spec[N];
  int ptr = 0;
  int checks = 0, errors = 0;
  bit done = 0;

  // stimulus staging
  logic [N-1:0] sRdy = '0, sMs = '0, sFd = '0, sLs = '0, sLd = '0, sSi = '0, sLh = '0, sLm = '0;

  task automatic cyc(input string tag);
    int expIdx;
    bit expV;
    logic [N-1:0] expG;
    @(negedge clk);
    threadReady = sRdy; missSet = sMs; fillDone = sFd; longOpSet = sLs;
    longOpDone = sLd; specIssue = sSi; loadHit = sLh; loadMiss = sLm;
    #1;
    expV = 0; expIdx = 0;
    for (int pass = 0; pass < 2; pass++) begin
      for (int off = 0; off < N; off++) begin
        int t = (ptr + off) % N;
        bit el = sRdy[t] && !mStall[t] && !lStall[t];
        if (!expV && el && (spec[t] == (pass == 1))) begin
          expV = 1; expIdx = t;
        end
      end
    end
    expG = '0;
    if (expV) expG[expIdx] = 1'b1;
    checks++;
    if (grantValid !== expV || grant !== expG) begin
      errors++;
      $display("FAIL %s: grant=%b valid=%b expected grant=%b valid=%b",
               tag, grant, grantValid, expG, expV);
    end
    if (expV) ptr = (expIdx + 1) % N;
    for (int t = 0; t < N; t++) begin
      mStall[t] = (mStall[t] && !sFd[t]) || sMs[t] || sLm[t];
      lStall[t] = (lStall[t] && !sLd[t]) || sLs[t];
      spec[t]   = (spec[t] && !(sLh[t] || sLm[t])) || sSi[t];
    end
    sMs = '0; sFd = '0; sLs = '0; sLd = '0; sSi = '0; sLh = '0; sLm = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R10: first grant after reset is thread 0
    sRdy = '1;
    cyc("R10");
    // R2: rotation across all ready threads
    repeat (6) cyc("R2");
    // R11: not-ready threads skipped
    sRdy = 4'b1010;
    repeat (4) cyc("R11");
    sRdy = '1;
    // R4: miss on thread 1, blocked until fill
    sMs = 4'b0010; cyc("R4");
    repeat (5) cyc("R4");
    sFd = 4'b0010; cyc("R4");
    repeat (4) cyc("R4");
    // R5: long op on thread 2, independent of miss wake
    sLs = 4'b0100; cyc("R5");
    sFd = 4'b0100; cyc("R5");
    repeat (3) cyc("R5");
    sLd = 4'b0100; cyc("R5");
    repeat (4) cyc("R5");
    // R6 / R3: thread 0 speculative, lower tier
    sSi = 4'b0001; cyc("R6");
    repeat (5) cyc("R3");
    sRdy = 4'b0001; repeat (2) cyc("R3");
    sRdy = '1;
    sLh = 4'b0001; cyc("R6");
    repeat (4) cyc("R6");
    // R7: speculative load on thread 3 misses
    sSi = 4'b1000; cyc("R7");
    sLm = 4'b1000; cyc("R7");
    repeat (4) cyc("R7");
    sFd = 4'b1000; cyc("R7");
    repeat (4) cyc("R7");
    // R8: nothing eligible, pointer holds
    sRdy = '0; repeat (3) cyc("R8");
    sRdy = '1; repeat (2) cyc("R8");
    // R9: set and clear in same cycle
    sMs = 4'b0001; sFd = 4'b0001; sLs = 4'b0010; sLd = 4'b0010; cyc("R9");
    repeat (4) cyc("R9");
    sFd = 4'b0001; sLd = 4'b0010; cyc("R9");
    sSi = 4'b0100; cyc("R9");
    sSi = 4'b0100; sLh = 4'b0100; cyc("R9");
    repeat (4) cyc("R9");
    sLh = 4'b0100; cyc("R9");
    repeat (3) cyc("R9");
    // mixed random traffic (R1, R2, R3 under all events)
    for (int k = 0; k < 2000; k++) begin
      sRdy = N'($urandom);
      for (int t = 0; t < N; t++) begin
        sMs[t] = ($urandom % 10) == 0;  sFd[t] = ($urandom % 4) == 0;
        sLs[t] = ($urandom % 12) == 0;  sLd[t] = ($urandom % 4) == 0;
        sSi[t] = ($urandom % 6) == 0;   sLh[t] = ($urandom % 5) == 0;
        sLm[t] = ($urandom % 12) == 0;
      end
      cyc("R1");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule